// File: doc/BRIEF.md
# General-Purpose Input Conditioner

This block turns one asynchronous logic pin into a fault source for a supply-supervision channel. The pin is first brought into the clock domain by a two-flop synchroniser. The result can be inverted. It is then used in one of two ways. In level mode it is taken as it is. In edge mode each rising edge of the conditioned signal becomes a pulse whose length counts ticks of a slow timebase.

A two-bit function selector decides what the channel reports. The fault can come from the paired analog detector, from the conditioned logic input, or from nothing at all. In a combined setting the logic input drives the fault and the analog detector's flag is lowered to a warning. The configuration byte and the function selector are static inputs. The timebase arrives as a single-cycle `tick` strobe.

Top module: `gpic_top`

## Requirements
- R1: The pin passes through two clock-edge flops. In level mode, with the logic input routed to `fault`, a pin change driven between edges shows on `fault` after the second rising clock edge and not after the first.
- R2: When `cfg_byte[6]` is 1, the synchronised pin is inverted before detection. When it is 0, the pin is used as it is.
- R3: When `cfg_byte[5]` is 0 (level mode), the logic fault equals the conditioned input on every cycle.
- R4: When `cfg_byte[5]` is 1 (edge mode), a 0-to-1 transition of the conditioned input starts a pulse. The pulse is visible on `fault` after the third rising clock edge that follows the pin change. A conditioned input that stays high raises no further pulse.
- R5: `cfg_byte[4:3]` sets the pulse length. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 ticks. The pulse ends on the clock edge of the last counted tick. A tick that coincides with the loading edge is not counted.
- R6: A new rising edge during an active pulse reloads the full length. The pulse then lasts the full count of ticks from that edge.
- R7: `func_sel` = 00 routes `det_fault` to `fault`, and `warn` is 0.
- R8: `func_sel` = 01 routes the logic input to `fault`, and `warn` is 0.
- R9: `func_sel` = 10 routes the logic input to `fault` and `det_fault` to `warn`.
- R10: `func_sel` = 11 holds both `fault` and `warn` at 0.
- R11: `cfg_byte[7]` and `cfg_byte[2:0]` have no effect on any output.
- R12: Reset clears the synchroniser and the pulse counter. In the first cycle after reset no edge is taken from the reset value, even when inversion makes the conditioned input start high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_raw | input | 1 | Asynchronous logic pin |
| det_fault | input | 1 | Fault flag from the paired analog detector |
| cfg_byte | input | 8 | Bit 6 invert, bit 5 edge mode, bits 4:3 pulse length code |
| func_sel | input | 2 | Fault/warning routing selector |
| tick | input | 1 | Single-cycle strobe of the slow timebase |
| fault | output | 1 | Channel fault flag |
| warn | output | 1 | Channel warning flag |

## Verification
A table of level-mode vectors walks every function-select value. Each row sets the pin, the detector flag and the invert bit so that `fault` and `warn` differ depending on which source is routed. This separates a swapped or dropped route and a missing inversion. Edge-mode runs send one rising edge per pulse-length code and count ticks up to one short of the expected length and then to the full length, which exposes an off-by-one count or a wrong code mapping. Further runs cover a tick that falls on the loading edge, a retrigger partway through a pulse, a held-high pin, the two-edge synchroniser latency and the reset-time inverted input. Each of these yields a different `fault` value if the counter fails to reload, if a level is taken as an edge, or if the edge detector is not primed after reset.

// File: rtl/gpic_pkg.sv
`timescale 1ns/1ps
package gpic_pkg;
  localparam int CFG_W    = 8;
  localparam int INV_BIT  = 6;
  localparam int MODE_BIT = 5;
  localparam int LEN_LSB  = 3;
  localparam int LEN_W    = 2;

  typedef enum logic [1:0] {
    FS_DET      = 2'b00,
    FS_PIN      = 2'b01,
    FS_PIN_WARN = 2'b10,
    FS_NONE     = 2'b11
  } fsel_e;

  typedef struct packed {
    logic             invert;
    logic             edge_mode;
    logic [LEN_W-1:0] len_code;
  } cond_cfg_t;

  // pulse length in ticks for a length code: doubling per step
  function automatic int unsigned pulse_ticks(input logic [LEN_W-1:0] code);
    return 32'd1 << code;
  endfunction

  localparam int unsigned MAX_TICKS = pulse_ticks({LEN_W{1'b1}});
  localparam int CNT_W = $clog2(MAX_TICKS + 1);
endpackage

// File: rtl/gpic_sync.sv
`timescale 1ns/1ps
module gpic_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpic_detect.sv
`timescale 1ns/1ps
module gpic_detect
  import gpic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_in,
  input  cond_cfg_t cfg,
  input  logic      tick,
  output logic      edge_evt,
  output logic      pulse_on,
  output logic      logic_flt
);
  logic             cond;
  logic             cond_prev_q;
  logic             primed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign cond     = sync_in ^ cfg.invert;
  assign edge_evt = primed_q & cond & ~cond_prev_q;
  assign load_val = CNT_W'(pulse_ticks(cfg.len_code));
  assign pulse_on = (cnt_q != '0);

  // history register; primed_q blocks an edge built from reset values
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_prev_q <= 1'b0;
      primed_q    <= 1'b0;
    end else begin
      cond_prev_q <= cond;
      primed_q    <= 1'b1;
    end
  end

  // pulse stretcher: load on edge (also retrigger), count down on ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!cfg.edge_mode)       cnt_q <= '0;
    else if (edge_evt)             cnt_q <= load_val;
    else if (tick && pulse_on)     cnt_q <= cnt_q - 1'b1;
  end

  assign logic_flt = cfg.edge_mode ? pulse_on : cond;

  p_edge_starts_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.edge_mode && edge_evt |=> pulse_on);

  p_tick_decrements_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.edge_mode && !edge_evt && tick && pulse_on |=> cnt_q == $past(cnt_q) - 1'b1);

  p_no_tick_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.edge_mode && !edge_evt && !tick |=> $stable(cnt_q));

  p_level_has_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.edge_mode |=> !pulse_on || cfg.edge_mode);
endmodule

// File: rtl/gpic_route.sv
`timescale 1ns/1ps
module gpic_route
  import gpic_pkg::*;
(
  input  fsel_e fsel,
  input  logic  logic_flt,
  input  logic  det_flt,
  output logic  fault,
  output logic  warn
);
  always_comb begin
    fault = 1'b0;
    warn  = 1'b0;
    unique case (fsel)
      FS_DET:      fault = det_flt;
      FS_PIN:      fault = logic_flt;
      FS_PIN_WARN: begin
        fault = logic_flt;
        warn  = det_flt;
      end
      FS_NONE:     ;
      default:     ;
    endcase
  end
endmodule

// File: rtl/gpic_top.sv
`timescale 1ns/1ps
module gpic_top
  import gpic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             det_fault,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic [1:0]       func_sel,
  input  logic             tick,
  output logic             fault,
  output logic             warn
);
  logic      pin_sync;
  cond_cfg_t cond_cfg;
  fsel_e     fsel;
  logic      edge_evt;
  logic      pulse_on;
  logic      logic_flt;
  logic      unused_cfg;

  assign cond_cfg   = {cfg_byte[INV_BIT], cfg_byte[MODE_BIT], cfg_byte[LEN_LSB +: LEN_W]};
  assign unused_cfg = ^{cfg_byte[7], cfg_byte[2:0]};
  assign fsel       = fsel_e'(func_sel);

  gpic_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_raw),
    .q_sync  (pin_sync)
  );

  gpic_detect detect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (pin_sync),
    .cfg       (cond_cfg),
    .tick      (tick),
    .edge_evt  (edge_evt),
    .pulse_on  (pulse_on),
    .logic_flt (logic_flt)
  );

  gpic_route route_i (
    .fsel      (fsel),
    .logic_flt (logic_flt),
    .det_flt   (det_fault),
    .fault     (fault),
    .warn      (warn)
  );

  p_warn_only_combined_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> func_sel == 2'b10 && det_fault);

  p_none_is_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    func_sel == 2'b11 |-> !fault && !warn);

  p_det_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    func_sel == 2'b00 |-> fault == det_fault && !warn);

  p_pulse_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    func_sel == 2'b01 && cfg_byte[MODE_BIT] |-> fault == pulse_on);
endmodule

// File: tb/gpic_top_tb.sv
`timescale 1ns/1ps
module gpic_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic       det_fault = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic [1:0] func_sel = 2'b01;
  logic       tick = 1'b0;
  logic       fault;
  logic       warn;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpic_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .det_fault(det_fault),
    .cfg_byte(cfg_byte), .func_sel(func_sel), .tick(tick),
    .fault(fault), .warn(warn)
  );

  // row: {fsel[1:0], invert, pin, det, exp_fault, exp_warn}, level mode
  localparam logic [6:0] VEC [12] = '{
    7'b00_0_0_1_1_0, 7'b00_0_1_0_0_0, 7'b00_1_1_0_0_0,
    7'b01_0_1_1_1_0, 7'b01_0_0_1_0_0, 7'b01_1_0_0_1_0,
    7'b01_1_1_1_0_0, 7'b10_0_1_0_1_0, 7'b10_0_0_1_0_1,
    7'b10_1_0_1_1_1, 7'b11_0_1_1_0_0, 7'b11_1_0_1_0_0
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  function automatic logic [7:0] mk_cfg(input logic b7, input logic inv, input logic edg,
                                        input logic [1:0] len, input logic [2:0] low);
    return {b7, inv, edg, len, low};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R12 / R1: reset holds the synchroniser cleared
    pin_raw = 1'b1; func_sel = 2'b01; cfg_byte = mk_cfg(0, 0, 0, 2'd0, 3'd0);
    wait_neg(3);
    check("R12", "fault during reset", fault, 1'b0);
    check("R12", "warn during reset", warn, 1'b0);

    // R12: inverted edge mode, constant low pin, no edge after release
    pin_raw = 1'b0; cfg_byte = mk_cfg(0, 1, 1, 2'd3, 3'd0);
    @(negedge clk); rst_n = 1'b1;
    wait_neg(4);
    check("R12", "no pulse from reset value", fault, 1'b0);

    // vector table: routing (R7..R10), inversion (R2), level follow (R3)
    for (int i = 0; i < 12; i++) begin
      logic [6:0] v;
      string rq;
      v = VEC[i];
      func_sel = v[6:5];
      cfg_byte = mk_cfg(0, v[4], 0, 2'd0, 3'd0);
      pin_raw = v[3]; det_fault = v[2];
      wait_neg(3);
      case (v[6:5])
        2'b00: rq = "R7";
        2'b01: rq = (v[4] ? "R2" : "R3");
        2'b10: rq = "R9";
        default: rq = "R10";
      endcase
      if (v[6:5] == 2'b01 && !v[4]) check("R8", $sformatf("row %0d fault", i), fault, v[1]);
      else check(rq, $sformatf("row %0d fault", i), fault, v[1]);
      check(rq, $sformatf("row %0d warn", i), warn, v[0]);
    end

    // R1: two-edge synchroniser latency in level mode
    func_sel = 2'b01; det_fault = 1'b0; cfg_byte = mk_cfg(0, 0, 0, 2'd0, 3'd0);
    pin_raw = 1'b0; wait_neg(3);
    pin_raw = 1'b1; wait_neg(1);
    check("R1", "after first edge", fault, 1'b0);
    wait_neg(1);
    check("R1", "after second edge", fault, 1'b1);

    // R11: unused bits set, level still follows the pin
    cfg_byte = mk_cfg(1, 0, 0, 2'd0, 3'b111);
    wait_neg(1);
    check("R11", "unused bits, pin high", fault, 1'b1);
    pin_raw = 1'b0; wait_neg(3);
    check("R11", "unused bits, pin low", fault, 1'b0);

    // R4: edge latency, then a held level raises nothing more
    cfg_byte = mk_cfg(0, 0, 1, 2'd1, 3'd0);
    wait_neg(2);
    pin_raw = 1'b1; wait_neg(2);
    check("R4", "before load edge", fault, 1'b0);
    wait_neg(1);
    check("R4", "pulse visible", fault, 1'b1);
    tick_n(2);
    check("R4", "pulse ended, pin held", fault, 1'b0);
    wait_neg(4);
    check("R4", "held level, no repulse", fault, 1'b0);

    // R5: every length code
    for (int c = 0; c < 4; c++) begin
      int len;
      len = 1 << c;
      cfg_byte = mk_cfg(0, 0, 1, c[1:0], 3'd0);
      pin_raw = 1'b0; wait_neg(3);
      tick_n(8);
      pin_raw = 1'b1; wait_neg(3);
      check("R5", $sformatf("code %0d start", c), fault, 1'b1);
      if (len > 1) begin
        tick_n(len - 1);
        check("R5", $sformatf("code %0d one tick short", c), fault, 1'b1);
      end
      tick_n(1);
      check("R5", $sformatf("code %0d expired", c), fault, 1'b0);
    end

    // R5: tick on the loading edge is not counted (code 0, one tick)
    cfg_byte = mk_cfg(0, 0, 1, 2'd0, 3'd0);
    pin_raw = 1'b0; wait_neg(3);
    pin_raw = 1'b1; wait_neg(2);
    tick = 1'b1; wait_neg(1); tick = 1'b0;
    check("R5", "tick at load ignored", fault, 1'b1);
    tick_n(1);
    check("R5", "tick at load, then expire", fault, 1'b0);

    // R2 in edge mode: falling pin starts a pulse when inverted
    cfg_byte = mk_cfg(0, 1, 1, 2'd0, 3'd0);
    wait_neg(3);
    tick_n(2);
    pin_raw = 1'b0; wait_neg(3);
    check("R2", "inverted falling edge pulse", fault, 1'b1);
    tick_n(1);
    check("R2", "inverted pulse expired", fault, 1'b0);

    // R6: retrigger reloads the full length (code 2 = 4 ticks)
    cfg_byte = mk_cfg(0, 0, 1, 2'd2, 3'd0);
    pin_raw = 1'b0; wait_neg(3);
    pin_raw = 1'b1; wait_neg(3);
    tick_n(2);
    pin_raw = 1'b0; wait_neg(3);
    pin_raw = 1'b1; wait_neg(3);
    tick_n(3);
    check("R6", "three ticks after retrigger", fault, 1'b1);
    tick_n(1);
    check("R6", "four ticks after retrigger", fault, 1'b0);

    // R9 / R10 with edge mode: warning and silence
    func_sel = 2'b10; det_fault = 1'b1; wait_neg(1);
    check("R9", "warn from detector", warn, 1'b1);
    func_sel = 2'b11; wait_neg(1);
    check("R10", "none selected warn", warn, 1'b0);

    finish_run();
  end
endmodule